// File: doc/BRIEF.md
# SDRAM Command Decoder and Ordering Checker

This block watches the command pins of a double-data-rate SDRAM at every rising clock edge. It turns each pin pattern into a one-hot command code. It expands the bank address into a mask of the banks the command targets. It also checks the command against a small model of the device state, and raises a one-cycle error pulse with a reason code when the command breaks an ordering rule.

The state model has three parts: an open or precharged flag for each of the four banks, a hold-off counter that runs after a mode-register write, and a window that starts with a write carrying auto precharge. All outputs are registered. The result for the pins sampled at a rising edge is visible from that edge until the next one. A command that is flagged leaves the state model unchanged.

The block is meant for a memory-controller testbench or for on-chip protocol monitoring. Data-path timing, strobe capture and refresh scheduling are not part of it.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: Synchronous active-low reset sets the command output to no-operation (bit 0) and clears the error output, the reason code, the bank mask and the auto-precharge flag. It marks all four banks precharged and clears both counters.
- R2: One-hot command bits are: 0 no-op, 1 mode set, 2 extended mode set, 3 activate, 4 read, 5 write, 6 precharge, 7 auto refresh, 8 self-refresh entry, 9 burst stop. The pin pattern {ras_n,cas_n,we_n} maps as follows: 000 is a mode set, 001 is a refresh, 010 is a precharge, 011 is an activate, 100 is a write, 101 is a read, 110 is a burst stop and 111 is a no-op. Any of these conditions gives a no-op: cs_n high, cke_prev low, or cke falling with any pattern other than 001.
- R3: For pattern 000, ba[0] low gives a mode set and ba[0] high gives an extended mode set. Either one with any bank open raises error code 1.
- R4: In the cycle after an accepted mode set or extended mode set, any command other than a no-op raises error code 3. Two cycles after it, commands are accepted again.
- R5: Pattern 001 with cke high is an auto refresh. With cke_prev high and cke low it is a self-refresh entry. Either one with any bank open raises error code 2.
- R6: For activate, read, write and precharge, the bank mask is 1<<{ba[1],ba[0]}. A precharge with addr[10] high gives the mask 4'b1111 and closes every bank, whatever ba is. All other commands give a mask of 0.
- R7: The auto-precharge output equals addr[10] for a read or a write, and is 0 for every other command.
- R8: An activate to an open bank raises error code 4. A read or write to a precharged bank raises error code 5. A flagged command changes no bank state, and the error lasts one cycle.
- R9: An accepted write with addr[10] high opens a window of BURST_LEN/2+WR_LAT cycles (3 by default) in which any read or write raises error code 6. When the window ends, that bank becomes precharged and reads or writes to other banks are accepted.
- R10: A burst stop is accepted without error. An accepted read with addr[10] high marks its bank precharged at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cke_prev | input | 1 | Clock enable as sampled one cycle earlier |
| cke | input | 1 | Clock enable in this cycle |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| addr | input | ADDR_W | Address bus; bit 10 is the auto-precharge / all-banks flag |
| cmd | output | 10 | One-hot decoded command |
| bank_sel | output | 4 | Mask of the targeted banks |
| auto_pre | output | 1 | Read or write carries auto precharge |
| err | output | 1 | Illegal-command pulse |
| err_code | output | 3 | Reason for the error, 0 when there is none |

## Verification
The hardest situation to reach is the end of the write-auto-precharge window. It is only reachable after two banks have been opened and a write with auto precharge has been accepted. After that, the rejected accesses have to land on exactly the right cycles. The stimulus opens banks 0 and 1 and issues the write to bank 0. It then places a read and a write to bank 1 inside the window, and one idle cycle on its last edge. Right after that it shows three things: bank 1 is accessible again, a read to bank 0 is rejected as closed, and an activate to bank 0 is accepted. The mode-set hold-off is reached the same way, by issuing an activate on the cycle right after the mode set and again one cycle later.

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor #(
  parameter int ADDR_W    = 12,
  parameter int BA_W      = 2,
  parameter int BURST_LEN = 4,
  parameter int WR_LAT    = 1,
  parameter int MRD_CYC   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke_prev,
  input  logic              cke,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [BA_W-1:0]   ba,
  input  logic [ADDR_W-1:0] addr,
  output logic [9:0]        cmd,
  output logic [(1<<BA_W)-1:0] bank_sel,
  output logic              auto_pre,
  output logic              err,
  output logic [2:0]        err_code
);
  localparam int NB     = 1 << BA_W;
  localparam int WIN    = BURST_LEN / 2 + WR_LAT;
  localparam int WW     = $clog2(WIN + 1);
  localparam int MW     = $clog2(MRD_CYC + 1);
  localparam int AP_BIT = 10;
  localparam int C_NOP = 0, C_MRS = 1, C_EMRS = 2, C_ACT = 3, C_RD = 4,
                 C_WR = 5, C_PRE = 6, C_REF = 7, C_SREF = 8, C_BST = 9;

  logic [NB-1:0]   open_q, open_d;
  logic [MW-1:0]   mrd_q;
  logic [WW-1:0]   wap_q;
  logic [BA_W-1:0] wap_bank_q;
  logic [9:0]      dec;
  logic [2:0]      code;

  always_comb begin
    dec = '0;
    if (!cke_prev || cs_n) dec[C_NOP] = 1'b1;
    else if (!cke) begin
      if ({ras_n, cas_n, we_n} == 3'b001) dec[C_SREF] = 1'b1;
      else dec[C_NOP] = 1'b1;
    end else begin
      unique case ({ras_n, cas_n, we_n})
        3'b000:  dec[ba[0] ? C_EMRS : C_MRS] = 1'b1;
        3'b001:  dec[C_REF] = 1'b1;
        3'b010:  dec[C_PRE] = 1'b1;
        3'b011:  dec[C_ACT] = 1'b1;
        3'b100:  dec[C_WR]  = 1'b1;
        3'b101:  dec[C_RD]  = 1'b1;
        3'b110:  dec[C_BST] = 1'b1;
        default: dec[C_NOP] = 1'b1;
      endcase
    end
  end

  wire [NB-1:0] ba_hot   = NB'(1) << ba;
  wire          bank_cmd = dec[C_ACT] | dec[C_RD] | dec[C_WR] | dec[C_PRE];
  wire          pre_all  = dec[C_PRE] & addr[AP_BIT];
  wire [NB-1:0] sel      = pre_all ? '1 : (bank_cmd ? ba_hot : '0);
  wire          rw       = dec[C_RD] | dec[C_WR];
  wire          all_idle = (open_q == '0);
  wire          tgt_open = |(open_q & ba_hot);
  wire          mode_cmd = dec[C_MRS] | dec[C_EMRS];
  wire          ref_cmd  = dec[C_REF] | dec[C_SREF];

  always_comb begin
    code = 3'd0;
    if (!dec[C_NOP] && mrd_q != '0)  code = 3'd3;
    else if (rw && wap_q != '0)      code = 3'd6;
    else if (mode_cmd && !all_idle)  code = 3'd1;
    else if (ref_cmd && !all_idle)   code = 3'd2;
    else if (dec[C_ACT] && tgt_open) code = 3'd4;
    else if (rw && !tgt_open)        code = 3'd5;
  end

  wire ok = (code == 3'd0);

  always_comb begin
    open_d = open_q;
    if (wap_q == WW'(1)) open_d[wap_bank_q] = 1'b0;
    if (ok) begin
      if (dec[C_ACT]) open_d = open_d | ba_hot;
      if (dec[C_PRE]) open_d = open_d & ~sel;
      if (dec[C_RD] && addr[AP_BIT]) open_d = open_d & ~ba_hot;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd        <= 10'd1;
      bank_sel   <= '0;
      auto_pre   <= 1'b0;
      err        <= 1'b0;
      err_code   <= 3'd0;
      open_q     <= '0;
      mrd_q      <= '0;
      wap_q      <= '0;
      wap_bank_q <= '0;
    end else begin
      cmd      <= dec;
      bank_sel <= sel;
      auto_pre <= rw & addr[AP_BIT];
      err      <= ~ok;
      err_code <= code;
      open_q   <= open_d;
      if (ok && mode_cmd)     mrd_q <= MW'(MRD_CYC - 1);
      else if (mrd_q != '0)   mrd_q <= mrd_q - 1'b1;
      if (ok && dec[C_WR] && addr[AP_BIT]) begin
        wap_q      <= WW'(WIN);
        wap_bank_q <= ba;
      end else if (wap_q != '0) wap_q <= wap_q - 1'b1;
    end
  end
endmodule

// File: rtl/sdram_cmd_monitor_chk.sv
module sdram_cmd_monitor_chk #(
  parameter int ADDR_W  = 12,
  parameter int NB      = 4,
  parameter int MRD_CYC = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic [9:0]        cmd,
  input logic [NB-1:0]     bank_sel,
  input logic              auto_pre,
  input logic              err,
  input logic [2:0]        err_code
);
  // R2
  one_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cmd) == 1);

  // R8
  err_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err == (err_code != 3'd0));

  // R4
  lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((MRD_CYC > 1) && (cmd[1] || cmd[2]) && !err) |=> (cmd[0] || err_code == 3'd3));

  // R6
  pre_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd[6] && $past(addr[10])) |-> bank_sel == '1);

  // R6
  nobank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd[3] || cmd[4] || cmd[5] || cmd[6]) |-> bank_sel == '0);

  // R7
  ap_only_rw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    auto_pre |-> (cmd[4] || cmd[5]));
endmodule

bind sdram_cmd_monitor sdram_cmd_monitor_chk #(.ADDR_W(ADDR_W), .NB(1 << BA_W), .MRD_CYC(MRD_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .cmd(cmd), .bank_sel(bank_sel),
  .auto_pre(auto_pre), .err(err), .err_code(err_code));

// File: tb/test_sdram_cmd_monitor.sv
module test_sdram_cmd_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int NOP = 1, MRS = 2, EMRS = 4, ACT = 8, RD = 16, WR = 32,
                 PRE = 64, REF = 128, SREF = 256, BST = 512;
  localparam logic [2:0] P_MRS = 3'b000, P_REF = 3'b001, P_PRE = 3'b010, P_ACT = 3'b011,
                         P_WR = 3'b100, P_RD = 3'b101, P_BST = 3'b110, P_NOP = 3'b111;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cke_prev = 1'b1, cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = '0;
  logic [11:0] addr = '0;
  logic [9:0] cmd;
  logic [3:0] bank_sel;
  logic auto_pre, err;
  logic [2:0] err_code;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_cmd_monitor i_sdram_cmd_monitor (
    .clk(clk), .rst_n(rst_n), .cke_prev(cke_prev), .cke(cke), .cs_n(cs_n),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
    .cmd(cmd), .bank_sel(bank_sel), .auto_pre(auto_pre), .err(err), .err_code(err_code));

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic raw(logic cp, logic ck, logic cs, logic [2:0] p, logic [1:0] b, logic [11:0] a);
    cke_prev = cp; cke = ck; cs_n = cs; {ras_n, cas_n, we_n} = p; ba = b; addr = a;
    @(negedge clk);
  endtask

  task automatic issue(logic [2:0] p, logic [1:0] b, logic a10);
    raw(1'b1, 1'b1, 1'b0, p, b, {1'b0, a10, 10'd5});
  endtask

  task automatic expect_ok(string req, int c, int mask);
    check(req, "cmd", cmd, c);
    check(req, "err", err, 0);
    check(req, "bank_sel", bank_sel, mask);
  endtask

  task automatic expect_err(string req, int c, int code);
    check(req, "cmd", cmd, c);
    check(req, "err", err, 1);
    check(req, "err_code", err_code, code);
  endtask

  task automatic t_reset();
    @(negedge clk); @(negedge clk);
    check("R1", "reset cmd", cmd, NOP);
    check("R1", "reset err", err, 0);
    check("R1", "reset code", err_code, 0);
    check("R1", "reset mask", bank_sel, 0);
    check("R1", "reset ap", auto_pre, 0);
    rst_n = 1'b1;
    for (int b = 0; b < 4; b++) begin
      issue(P_ACT, 2'(b), 1'b0);
      expect_ok("R1", ACT, 1 << b);
    end
    issue(P_PRE, 2'd0, 1'b1);
    expect_ok("R6", PRE, 15);
  endtask

  task automatic t_decode();
    raw(1'b1, 1'b1, 1'b1, P_MRS, 2'd0, '0);
    expect_ok("R2", NOP, 0);
    issue(P_NOP, 2'd0, 1'b0);
    expect_ok("R2", NOP, 0);
    raw(1'b0, 1'b1, 1'b0, P_ACT, 2'd1, '0);
    expect_ok("R2", NOP, 0);
    raw(1'b1, 1'b0, 1'b0, P_ACT, 2'd1, '0);
    expect_ok("R2", NOP, 0);
    issue(P_BST, 2'd2, 1'b0);
    expect_ok("R10", BST, 0);
  endtask

  task automatic t_banks();
    issue(P_ACT, 2'd2, 1'b0);
    expect_ok("R6", ACT, 4);
    issue(P_ACT, 2'd2, 1'b0);
    expect_err("R8", ACT, 4);
    issue(P_NOP, 2'd0, 1'b0);
    check("R8", "err pulse", err, 0);
    issue(P_RD, 2'd2, 1'b0);
    expect_ok("R8", RD, 4);
    check("R7", "ap read", auto_pre, 0);
    issue(P_WR, 2'd2, 1'b0);
    expect_ok("R7", WR, 4);
    check("R7", "ap write", auto_pre, 0);
    issue(P_RD, 2'd3, 1'b0);
    expect_err("R8", RD, 5);
    issue(P_ACT, 2'd3, 1'b0);
    expect_ok("R6", ACT, 8);
    issue(P_PRE, 2'd3, 1'b0);
    expect_ok("R6", PRE, 8);
    issue(P_RD, 2'd3, 1'b0);
    expect_err("R6", RD, 5);
    issue(P_RD, 2'd2, 1'b0);
    expect_ok("R6", RD, 4);
    issue(P_PRE, 2'd1, 1'b1);
    expect_ok("R6", PRE, 15);
    issue(P_WR, 2'd2, 1'b0);
    expect_err("R6", WR, 5);
  endtask

  task automatic t_mode();
    issue(P_ACT, 2'd0, 1'b0);
    issue(P_MRS, 2'd0, 1'b0);
    expect_err("R3", MRS, 1);
    issue(P_PRE, 2'd0, 1'b1);
    issue(P_MRS, 2'd0, 1'b0);
    expect_ok("R3", MRS, 0);
    issue(P_ACT, 2'd1, 1'b0);
    expect_err("R4", ACT, 3);
    issue(P_ACT, 2'd1, 1'b0);
    expect_ok("R4", ACT, 2);
    issue(P_PRE, 2'd0, 1'b1);
    issue(P_NOP, 2'd0, 1'b0);
    issue(P_MRS, 2'd1, 1'b0);
    expect_ok("R3", EMRS, 0);
    issue(P_NOP, 2'd0, 1'b0);
    expect_ok("R4", NOP, 0);
    issue(P_ACT, 2'd0, 1'b0);
    expect_ok("R4", ACT, 1);
    issue(P_PRE, 2'd0, 1'b1);
  endtask

  task automatic t_refresh();
    issue(P_REF, 2'd0, 1'b0);
    expect_ok("R5", REF, 0);
    raw(1'b1, 1'b0, 1'b0, P_REF, 2'd0, '0);
    expect_ok("R5", SREF, 0);
    raw(1'b0, 1'b1, 1'b1, P_NOP, 2'd0, '0);
    expect_ok("R5", NOP, 0);
    issue(P_ACT, 2'd1, 1'b0);
    issue(P_REF, 2'd0, 1'b0);
    expect_err("R5", REF, 2);
    raw(1'b1, 1'b0, 1'b0, P_REF, 2'd0, '0);
    expect_err("R5", SREF, 2);
    issue(P_PRE, 2'd0, 1'b1);
  endtask

  task automatic t_wap();
    issue(P_ACT, 2'd0, 1'b0);
    issue(P_ACT, 2'd1, 1'b0);
    issue(P_WR, 2'd0, 1'b1);
    expect_ok("R9", WR, 1);
    check("R7", "ap write", auto_pre, 1);
    issue(P_RD, 2'd1, 1'b0);
    expect_err("R9", RD, 6);
    issue(P_WR, 2'd1, 1'b0);
    expect_err("R9", WR, 6);
    issue(P_NOP, 2'd0, 1'b0);
    issue(P_RD, 2'd1, 1'b0);
    expect_ok("R9", RD, 2);
    issue(P_RD, 2'd0, 1'b0);
    expect_err("R9", RD, 5);
    issue(P_ACT, 2'd0, 1'b0);
    expect_ok("R9", ACT, 1);
    issue(P_RD, 2'd1, 1'b1);
    expect_ok("R10", RD, 2);
    check("R10", "ap read", auto_pre, 1);
    issue(P_WR, 2'd1, 1'b0);
    expect_err("R10", WR, 5);
    issue(P_PRE, 2'd0, 1'b1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_decode();
    t_banks();
    t_mode();
    t_refresh();
    t_wap();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule